// File: doc/BRIEF.md
# Dual-Slope Conversion Controller

This block is the digital sequencer of an integrating dual-slope analog-to-digital converter. It steers an input-select switch (ground, unknown input, negative reference), works the integrator shorting switch, and runs a binary counter. The only analog information it receives is a single comparator bit that tells whether the integrator output is still above zero.

A start pulse launches a conversion. The unknown input is integrated for a fixed window of 2^N clocks while the counter runs. At the end of that window the counter clears and the negative reference is applied. The counter then advances once per clock until the synchronized comparator reports the zero crossing. At that point the counter value is captured as the result, a one-clock done strobe is raised, and the switches return to their idle setting. If the counter reaches full scale first, the result saturates and an over-range flag is set.

Top module: `dslope_ctrl`

## Requirements
- R1: While reset or idle, `sel_o` is 2'b00 (ground), `zero_sw_o` is 1 (integrator shorted), `count_o` is 0 and `done_o` is 0.
- R2: The clock edge that samples `start_i` high in idle sets `sel_o` to 2'b01 (unknown input) and `zero_sw_o` to 0.
- R3: `sel_o` stays at 2'b01 for exactly 2^N clocks, and during that window `count_o` steps by one per clock from 0 to 2^N-1.
- R4: When the fixed window ends, `sel_o` becomes 2'b10 (negative reference) in the same clock in which `count_o` returns to 0.
- R5: While `sel_o` is 2'b10, `count_o` increases by one on every clock until the conversion ends.
- R6: `cmp_i` is 1 while the integrator output is above zero and passes through two flops before use. If it first falls K clocks (K ≥ 1) after the reference is applied, `result_o` is K+2. If it is already low when the reference is applied, `result_o` is 0.
- R7: If `count_o` reaches 2^N-1 in the reference phase while the synchronized comparator is still 1, `result_o` becomes 2^N-1 and `over_o` becomes 1. `over_o` stays set until the next start, which clears it.
- R8: Each conversion produces exactly one `done_o` pulse, one clock wide. During that pulse `sel_o` is already 2'b00 and `zero_sw_o` is 1.
- R9: A `start_i` pulse during a conversion is ignored. It does not change the timing, the result or the number of done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Conversion request, sampled in idle |
| cmp_i | input | 1 | Comparator: 1 while integrator output is above zero |
| sel_o | output | 2 | Input select: 00 ground, 01 unknown input, 10 negative reference |
| zero_sw_o | output | 1 | Integrator shorting switch, 1 = closed |
| count_o | output | N | Phase counter |
| result_o | output | N | Captured conversion result |
| done_o | output | 1 | One-clock end-of-conversion strobe |
| over_o | output | 1 | Over-range flag for the last conversion |

## Verification
The embedded assertions check the cycle-level rules on every cycle: the switch setting that follows a start, the counter stepping by one in each active phase, the clear at the phase boundary, the single-cycle done pulse, the saturated value that comes with over-range, and the flag clearing on a new start. Only the bench scenarios can show the end-to-end numbers. These are the exact window length, the K+2 result that includes the synchronizer delay, the already-low and just-saturating corner cases, and the fact that a stray start is ignored. For those, a behavioural integrator closes the loop around the block.

// File: rtl/dslope_ctrl.sv
module dslope_ctrl #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic         cmp_i,
  output logic [1:0]   sel_o,
  output logic         zero_sw_o,
  output logic [N-1:0] count_o,
  output logic [N-1:0] result_o,
  output logic         done_o,
  output logic         over_o
);

  localparam logic [N-1:0] CNT_MAX = '1;
  localparam logic [1:0]   SEL_GND = 2'b00;
  localparam logic [1:0]   SEL_VIN = 2'b01;
  localparam logic [1:0]   SEL_REF = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_INT, S_DEI} st_t;

  st_t  st;
  logic cmp_m, cmp_s;
  logic at_max;

  assign at_max    = (count_o == CNT_MAX);
  assign sel_o     = (st == S_INT) ? SEL_VIN : (st == S_DEI) ? SEL_REF : SEL_GND;
  assign zero_sw_o = (st == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_m <= 1'b0;
      cmp_s <= 1'b0;
    end else begin
      cmp_m <= cmp_i;
      cmp_s <= cmp_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      count_o  <= '0;
      result_o <= '0;
      done_o   <= 1'b0;
      over_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (st)
        S_IDLE: begin
          count_o <= '0;
          if (start_i) begin
            st     <= S_INT;
            over_o <= 1'b0;
          end
        end
        S_INT: begin
          if (at_max) begin
            count_o <= '0;
            st      <= S_DEI;
          end else begin
            count_o <= count_o + 1'b1;
          end
        end
        S_DEI: begin
          if (!cmp_s) begin
            result_o <= count_o;
            done_o   <= 1'b1;
            count_o  <= '0;
            st       <= S_IDLE;
          end else if (at_max) begin
            result_o <= CNT_MAX;
            over_o   <= 1'b1;
            done_o   <= 1'b1;
            count_o  <= '0;
            st       <= S_IDLE;
          end else begin
            count_o <= count_o + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_START_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_o) == SEL_GND && sel_o != SEL_GND) |-> (sel_o == SEL_VIN && !zero_sw_o)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o != SEL_GND && sel_o == $past(sel_o)) |-> count_o == $past(count_o) + 1'b1); // R5

  AST_PHASE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == SEL_REF && $past(sel_o) == SEL_VIN) |-> (count_o == '0 && $past(count_o) == CNT_MAX)); // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (sel_o == SEL_GND && zero_sw_o)); // R8

  AST_OVER_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && over_o) |-> result_o == CNT_MAX); // R7

  AST_OVER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sel_o) == SEL_GND && sel_o == SEL_VIN) |-> !over_o); // R7

endmodule

// File: tb/dslope_ctrl_test.sv
module dslope_ctrl_test;
  localparam int N   = 6;
  localparam int WIN = 1 << N;
  localparam int MAXV = WIN - 1;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0;
  logic cmp_i;
  logic [1:0] sel_o;
  logic zero_sw_o, done_o, over_o;
  logic [N-1:0] count_o, result_o;

  int checks = 0, errors = 0, cyc = 0;
  int integ = 0, vin = 0, vref = 1;
  int vin_cycles = 0, done_cnt = 0;
  logic [1:0] prev_sel = 2'b00;
  int prev_cnt = 0;

  always #10 clk = ~clk;

  dslope_ctrl #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .sel_o(sel_o), .zero_sw_o(zero_sw_o), .count_o(count_o),
    .result_o(result_o), .done_o(done_o), .over_o(over_o)
  );

  assign cmp_i = (integ > 0);

  always @(posedge clk) begin
    if (zero_sw_o) integ <= 0;
    else if (sel_o == 2'b01) integ <= integ + vin;
    else if (sel_o == 2'b10) integ <= integ - vref;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (sel_o == 2'b01) vin_cycles++;
    if (done_o) done_cnt++;
    if (prev_sel == 2'b01 && sel_o == 2'b10) begin
      check(count_o == 0, "R4 count clears at boundary", int'(count_o), 0);
      check(prev_cnt == MAXV, "R3 last integrate count", prev_cnt, MAXV);
    end
    prev_sel = sel_o;
    prev_cnt = int'(count_o);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", cyc, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam int NV = 8;
  localparam int TBL [NV][4] = '{
    '{1, 64, 3, 0},
    '{1, 8, 10, 0},
    '{3, 8, 26, 0},
    '{7, 8, 58, 0},
    '{15, 16, 62, 0},
    '{61, 64, 63, 0},
    '{62, 64, 63, 1},
    '{200, 64, 63, 1}
  };

  task automatic convert(input int v, input int r, input int exp_res, input int exp_ov,
                         input bit stray, input string tag);
    int waited;
    vin = v; vref = r;
    vin_cycles = 0; done_cnt = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    check(sel_o == 2'b01 && !zero_sw_o, "R2 start switches", int'(sel_o), 1);
    waited = 0;
    while (!done_o && waited < 400) begin
      @(negedge clk);
      waited++;
      if (stray && waited == 20) start_i = 1'b1;
      if (stray && waited == 21) start_i = 1'b0;
      if (stray && waited == WIN + 5) start_i = 1'b1;
      if (stray && waited == WIN + 6) start_i = 1'b0;
    end
    check(done_o == 1'b1, {tag, " R8 done seen"}, int'(done_o), 1);
    check(int'(result_o) == exp_res, {tag, " R6 result"}, int'(result_o), exp_res);
    check(int'(over_o) == exp_ov, {tag, " R7 over flag"}, int'(over_o), exp_ov);
    check(vin_cycles == WIN, {tag, " R3 window length"}, vin_cycles, WIN);
    check(sel_o == 2'b00 && zero_sw_o, {tag, " R8 idle switches on done"}, int'(sel_o), 0);
    @(negedge clk);
    check(!done_o, {tag, " R8 done one clock"}, int'(done_o), 0);
    repeat (3) @(negedge clk);
    check(done_cnt == 1 && sel_o == 2'b00, {tag, " R9 single conversion"}, done_cnt, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(sel_o == 2'b00 && zero_sw_o && count_o == 0 && !done_o, "R1 reset state", int'(sel_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sel_o == 2'b00 && zero_sw_o && count_o == 0, "R1 idle state", int'(count_o), 0);

    for (int i = 0; i < NV; i++)
      convert(TBL[i][0], TBL[i][1], TBL[i][2], TBL[i][3], 1'b0, $sformatf("vec%0d", i));

    convert(0, 8, 0, 0, 1'b0, "R6 already low");
    convert(2, 8, 18, 0, 1'b0, "R7 over cleared by start");
    convert(5, 8, 42, 0, 1'b1, "R9 stray start");

    vin = 4; vref = 8;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    repeat (5) @(negedge clk);
    check(int'(count_o) == 5, "R3 counting in window", int'(count_o), 5);
    repeat (WIN - 5) @(negedge clk);
    repeat (4) @(negedge clk);
    check(sel_o == 2'b10 && int'(count_o) == 4, "R5 reference count", int'(count_o), 4);
    while (!done_o) @(negedge clk);
    check(int'(result_o) == 34, "R6 result K=32", int'(result_o), 34);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule